// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the 256-byte configuration space of a single PCI function and serves reads and writes of one, two or four bytes at any byte offset. Multi-byte data is little-endian: lane 0 of the data word carries the byte at the requested offset, lane 1 the next byte, and so on. Offsets wrap modulo 256. Identity bytes, the header type, the interrupt pin and the base address register (BAR) types are parameters. They are loaded into the storage at reset.

Writes go through a per-byte protection rule that depends on the stored header type byte. An aligned full-word write to an implemented BAR takes a shaping path that aligns the value to the region size and restores the type bits. The same path on the expansion ROM register keeps bit 0 as the enable. The block drives the command register, every BAR, the ROM register and a one-cycle update pulse out to a neighbour, which uses them to recompute its address windows.

Requests use a valid/ready channel. Read data comes back on a valid/ready response channel one cycle after the read is accepted. `req_ready` is low only while a read response is held and `rsp_ready` is low, so a stalled consumer stalls the request side too. A held response keeps its data stable. Writes are accepted under the same rule and produce no response.

Top module: `pcfg_regfile`

## Requirements
- R1: A read accepted with size code 0, 1 or 2 returns 1, 2 or 4 bytes (code 3 also returns 4). The byte at offset+i (mod 256) appears on data bits [8i+7:8i], and lanes past the length read as zero.
- R2: `rsp_valid` rises the cycle after a read is accepted. While `rsp_valid` is high and `rsp_ready` is low, the response data stays unchanged and `req_ready` is low.
- R3: After reset, bytes 0x00–0x01 hold the vendor ID and 0x02–0x03 the device ID. Byte 0x08 holds the revision, 0x09–0x0B the class code, 0x0E the header type and 0x3D the interrupt pin, and each BAR with non-zero size holds its type value. Every other byte is zero.
- R4: With header type 0x00 or 0x80, byte-path writes leave these bytes unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D, 0x10–0x27 and 0x30–0x33.
- R5: With any other header type, byte-path writes leave these bytes unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D and 0x38–0x3B.
- R6: On the byte path, every unprotected byte offset+i within the access length takes data lane i.
- R7: A 4-byte write at aligned offset 0x10+4·n to a BAR with non-zero size stores (data AND NOT(size−1)) OR type, whatever the header type.
- R8: A 4-byte write at offset 0x30 with a non-zero ROM size stores data AND (NOT(size−1) OR 1).
- R9: Writes of 1 or 2 bytes, unaligned 4-byte writes, and writes to a BAR or ROM of size zero do not take the shaping path. They follow the byte path instead.
- R10: `map_update` is high for exactly the cycle after an accepted write that took the shaping path or whose byte range covers offset 0x04 or 0x05. It is low in every other cycle.
- R11: `cmd_reg` shows bytes 0x05:0x04, `bar_vec` slice n shows bytes 0x13+4n..0x10+4n, and `rom_reg` shows bytes 0x33..0x30. Each holds its value except in the cycle after an accepted write.
- R12: An accepted write never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into configuration space |
| req_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data, lane i for offset+i |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| cmd_reg | output | 16 | Command register |
| bar_vec | output | 32·NBAR | All BAR values, BAR n in slice n |
| rom_reg | output | 32 | Expansion ROM register |
| map_update | output | 1 | Pulse: mapping-relevant register written |

## Verification
Two things can happen at the same clock edge: a held read response drains, and a write that waited behind it is accepted. The bench provokes this by stalling `rsp_ready` with a read response pending while a command-register write is already presented. It checks that `req_ready` stays low for the whole stall and the response data does not move. Then it releases `rsp_ready` and, in the following cycle, checks that the response has gone, that `map_update` fires, and that the command value matches the arithmetic model.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    ACC_B1  = 2'd0,
    ACC_B2  = 2'd1,
    ACC_B4  = 2'd2,
    ACC_B4X = 2'd3
  } acc_size_e;

  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned BAR_SLOTS = 6;
  localparam logic [7:0]  OFS_CMD   = 8'h04;
  localparam logic [7:0]  OFS_BAR0  = 8'h10;
  localparam logic [7:0]  OFS_ROM   = 8'h30;
  localparam logic [7:0]  OFS_HDR   = 8'h0E;
  localparam logic [7:0]  OFS_PIN   = 8'h3D;

  function automatic logic [2:0] acc_bytes(acc_size_e s);
    case (s)
      ACC_B1:  return 3'd1;
      ACC_B2:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Byte-granular write protection, selected by the header type byte.
  function automatic logic is_locked(logic [7:0] hdr, logic [7:0] a);
    logic common;
    common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) ||
             (a == OFS_HDR) || (a == OFS_PIN);
    if (hdr == 8'h00 || hdr == 8'h80)
      return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    return common || (a >= 8'h38 && a <= 8'h3B);
  endfunction

endpackage

// File: rtl/pcfg_lane_guard.sv
module pcfg_lane_guard
  import pcfg_pkg::*;
(
  input  logic [7:0]       hdr,
  input  logic [7:0]       base,
  input  logic [2:0]       nbytes,
  input  logic             wr_go,
  output logic [3:0][7:0]  lane_addr,
  output logic [3:0]       lane_we,
  output logic             cmd_touch
);

  logic [3:0] lane_cov;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_lane
      logic in_len;
      assign lane_addr[g] = base + 8'(g);
      assign in_len       = (3'(g) < nbytes);
      assign lane_we[g]   = wr_go && in_len && !is_locked(hdr, lane_addr[g]);
      assign lane_cov[g]  = in_len &&
                            (lane_addr[g] == OFS_CMD || lane_addr[g] == OFS_CMD + 8'd1);
    end
  endgenerate

  assign cmd_touch = |lane_cov;

endmodule

// File: rtl/pcfg_region_shaper.sv
module pcfg_region_shaper #(
  parameter int unsigned               NBAR     = 6,
  parameter logic [NBAR-1:0][31:0]     BAR_SIZE = '0,
  parameter logic [NBAR-1:0][31:0]     BAR_TYPE = '0,
  parameter logic [31:0]               ROM_SIZE = 32'h0
) (
  input  logic [7:0]  base,
  input  logic        full_word,
  input  logic [31:0] wdata,
  output logic        hit,
  output logic [31:0] shaped
);
  import pcfg_pkg::*;

  localparam int unsigned NREG = NBAR + 1;

  logic [NREG-1:0]       sel;
  logic [NREG-1:0][31:0] val;

  genvar g;
  generate
    for (g = 0; g < NBAR; g++) begin : g_bar
      localparam logic [7:0]  OFS  = 8'(16 + 4 * g);
      localparam logic [31:0] KEEP = ~(BAR_SIZE[g] - 32'd1);
      assign sel[g] = full_word && (base == OFS) && (BAR_SIZE[g] != 32'd0);
      assign val[g] = (wdata & KEEP) | BAR_TYPE[g];
    end
  endgenerate

  localparam logic [31:0] ROM_KEEP = ~(ROM_SIZE - 32'd1) | 32'd1;
  assign sel[NBAR] = full_word && (base == OFS_ROM) && (ROM_SIZE != 32'd0);
  assign val[NBAR] = wdata & ROM_KEEP;

  always_comb begin
    shaped = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) shaped = shaped | val[i];
  end

  assign hit = |sel;

endmodule

// File: rtl/pcfg_byte_store.sv
module pcfg_byte_store #(
  parameter logic [255:0][7:0] RST_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        lane_we,
  input  logic [3:0][7:0]   lane_addr,
  input  logic [31:0]       lane_data,
  input  logic              word_we,
  input  logic [7:0]        word_addr,
  input  logic [31:0]       word_data,
  input  logic [7:0]        rd_addr,
  input  logic [2:0]        rd_n,
  output logic [31:0]       rd_data,
  output logic [255:0][7:0] image
);

  logic [255:0][7:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= RST_IMAGE;
    end else if (word_we) begin
      for (int k = 0; k < 4; k++)
        mem[word_addr + 8'(k)] <= word_data[8*k +: 8];
    end else begin
      for (int k = 0; k < 4; k++)
        if (lane_we[k]) mem[lane_addr[k]] <= lane_data[8*k +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < rd_n) rd_data[8*k +: 8] = mem[rd_addr + 8'(k)];
  end

  assign image = mem;

endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
  import pcfg_pkg::*;
#(
  parameter int unsigned           NBAR        = 6,
  parameter logic [NBAR-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h1000, 32'h20, 32'h100},
  parameter logic [NBAR-1:0][31:0] BAR_TYPE    = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
  parameter logic [31:0]           ROM_SIZE    = 32'h800,
  parameter logic [15:0]           VENDOR_ID   = 16'h1B36,
  parameter logic [15:0]           DEVICE_ID   = 16'h0007,
  parameter logic [7:0]            REVISION    = 8'h02,
  parameter logic [23:0]           CLASS_CODE  = 24'h020000,
  parameter logic [7:0]            HEADER_TYPE = 8'h00,
  parameter logic [7:0]            INT_PIN     = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [7:0]           req_offset,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic [15:0]          cmd_reg,
  output logic [NBAR*32-1:0]   bar_vec,
  output logic [31:0]          rom_reg,
  output logic                 map_update
);

  function automatic logic [255:0][7:0] build_image();
    logic [255:0][7:0] im;
    im      = '0;
    im[0]   = VENDOR_ID[7:0];
    im[1]   = VENDOR_ID[15:8];
    im[2]   = DEVICE_ID[7:0];
    im[3]   = DEVICE_ID[15:8];
    im[8]   = REVISION;
    im[9]   = CLASS_CODE[7:0];
    im[10]  = CLASS_CODE[15:8];
    im[11]  = CLASS_CODE[23:16];
    im[14]  = HEADER_TYPE;
    im[61]  = INT_PIN;
    for (int b = 0; b < NBAR; b++)
      if (BAR_SIZE[b] != 32'd0)
        for (int k = 0; k < 4; k++)
          im[16 + 4*b + k] = BAR_TYPE[b][8*k +: 8];
    return im;
  endfunction

  localparam logic [255:0][7:0] RST_IMAGE = build_image();

  acc_size_e         sz;
  logic [2:0]        nbytes;
  logic              accept;
  logic              wr_go;
  logic              full_word;
  logic              shape_hit;
  logic [31:0]       shaped;
  logic [3:0][7:0]   lane_addr;
  logic [3:0]        lane_we;
  logic              cmd_touch;
  logic [31:0]       rd_data;
  logic [255:0][7:0] image;

  assign sz        = acc_size_e'(req_size);
  assign nbytes    = acc_bytes(sz);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_go     = accept && req_write;
  assign full_word = (nbytes == 3'd4) && (req_offset[1:0] == 2'b00);

  pcfg_region_shaper #(
    .NBAR     (NBAR),
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE),
    .ROM_SIZE (ROM_SIZE)
  ) u_shaper (
    .base      (req_offset),
    .full_word (full_word),
    .wdata     (req_wdata),
    .hit       (shape_hit),
    .shaped    (shaped)
  );

  pcfg_lane_guard u_guard (
    .hdr       (image[OFS_HDR]),
    .base      (req_offset),
    .nbytes    (nbytes),
    .wr_go     (wr_go && !shape_hit),
    .lane_addr (lane_addr),
    .lane_we   (lane_we),
    .cmd_touch (cmd_touch)
  );

  pcfg_byte_store #(
    .RST_IMAGE (RST_IMAGE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (req_wdata),
    .word_we   (wr_go && shape_hit),
    .word_addr (req_offset),
    .word_data (shaped),
    .rd_addr   (req_offset),
    .rd_n      (nbytes),
    .rd_data   (rd_data),
    .image     (image)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      map_update <= 1'b0;
    end else begin
      map_update <= wr_go && (shape_hit || cmd_touch);
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign cmd_reg = {image[OFS_CMD + 8'd1], image[OFS_CMD]};
  assign rom_reg = {image[OFS_ROM + 8'd3], image[OFS_ROM + 8'd2],
                    image[OFS_ROM + 8'd1], image[OFS_ROM]};

  genvar g;
  generate
    for (g = 0; g < NBAR; g++) begin : g_bar_out
      localparam int unsigned B = 16 + 4 * g;
      assign bar_vec[32*g +: 32] = {image[B+3], image[B+2], image[B+1], image[B]};
    end
  endgenerate

endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker #(
  parameter int unsigned           NBAR        = 6,
  parameter logic [NBAR-1:0][31:0] BAR_SIZE    = '0,
  parameter logic [NBAR-1:0][31:0] BAR_TYPE    = '0,
  parameter logic [31:0]           ROM_SIZE    = 32'h0,
  parameter logic [7:0]            HEADER_TYPE = 8'h00
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [31:0]        rsp_rdata,
  input logic [15:0]        cmd_reg,
  input logic [NBAR*32-1:0] bar_vec,
  input logic [31:0]        rom_reg,
  input logic               map_update
);

  localparam bit HDR_STD = (HEADER_TYPE == 8'h00) || (HEADER_TYPE == 8'h80);

  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);  // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));  // R2

  AST_WRITE_NORSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);  // R12

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    map_update |-> $past(req_valid && req_ready && req_write));  // R10

  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready && req_write) |-> $stable(cmd_reg));  // R11

  genvar g;
  generate
    for (g = 0; g < NBAR; g++) begin : g_bar_chk
      if (HDR_STD && BAR_SIZE[g] != 32'd0) begin : g_on
        AST_BAR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
          (bar_vec[32*g +: 32] & (BAR_SIZE[g] - 32'd1)) == BAR_TYPE[g]);  // R7
      end
    end
    if (HDR_STD && ROM_SIZE != 32'd0) begin : g_rom_chk
      AST_ROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_reg & (ROM_SIZE - 32'd1) & ~32'd1) == 32'd0);  // R8
    end
  endgenerate

endmodule

bind pcfg_regfile pcfg_checker #(
  .NBAR        (NBAR),
  .BAR_SIZE    (BAR_SIZE),
  .BAR_TYPE    (BAR_TYPE),
  .ROM_SIZE    (ROM_SIZE),
  .HEADER_TYPE (HEADER_TYPE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .cmd_reg    (cmd_reg),
  .bar_vec    (bar_vec),
  .rom_reg    (rom_reg),
  .map_update (map_update)
);

// File: tb/pcfg_regfile_test.sv
module pcfg_regfile_test;

  localparam int unsigned         NB    = 6;
  localparam logic [NB-1:0][31:0] BSZ   = {32'h0, 32'h0, 32'h0, 32'h1000, 32'h20, 32'h100};
  localparam logic [NB-1:0][31:0] BTY   = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0};
  localparam logic [31:0]         ROMSZ = 32'h800;
  localparam logic [15:0]         VID   = 16'h1B36;
  localparam logic [15:0]         DID   = 16'h0007;
  localparam logic [7:0]          REV   = 8'h02;
  localparam logic [23:0]         CLS   = 24'h020000;
  localparam logic [7:0]          PIN   = 8'h01;
  localparam logic [7:0]          HDR_A = 8'h00;
  localparam logic [7:0]          HDR_B = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_offset = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;

  logic req_ready_a, rsp_valid_a, map_update_a;
  logic [31:0] rsp_rdata_a, rom_a;
  logic [15:0] cmd_a;
  logic [NB*32-1:0] bar_a;
  logic req_ready_b, rsp_valid_b, map_update_b;
  logic [31:0] rsp_rdata_b, rom_b;
  logic [15:0] cmd_b;
  logic [NB*32-1:0] bar_b;

  always #10 clk = ~clk;

  pcfg_regfile #(.NBAR(NB), .BAR_SIZE(BSZ), .BAR_TYPE(BTY), .ROM_SIZE(ROMSZ),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .HEADER_TYPE(HDR_A), .INT_PIN(PIN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_a),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata_a), .cmd_reg(cmd_a), .bar_vec(bar_a), .rom_reg(rom_a),
    .map_update(map_update_a));

  pcfg_regfile #(.NBAR(NB), .BAR_SIZE(BSZ), .BAR_TYPE(BTY), .ROM_SIZE(ROMSZ),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .HEADER_TYPE(HDR_B), .INT_PIN(PIN)) uut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_b),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata_b), .cmd_reg(cmd_b), .bar_vec(bar_b), .rom_reg(rom_b),
    .map_update(map_update_b));

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mdl [0:1][0:255];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic bit locked(logic [7:0] h, logic [7:0] a);
    bit c;
    c = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == 8'h0E || a == 8'h3D;
    if (h == 8'h00 || h == 8'h80)
      return c || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    return c || (a >= 8'h38 && a <= 8'h3B);
  endfunction

  function automatic int nbytes_of(logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_init(int u, logic [7:0] h);
    for (int a = 0; a < 256; a++) mdl[u][a] = 8'h00;
    mdl[u][0] = VID[7:0]; mdl[u][1] = VID[15:8];
    mdl[u][2] = DID[7:0]; mdl[u][3] = DID[15:8];
    mdl[u][8] = REV; mdl[u][9] = CLS[7:0]; mdl[u][10] = CLS[15:8]; mdl[u][11] = CLS[23:16];
    mdl[u][14] = h; mdl[u][61] = PIN;
    for (int b = 0; b < NB; b++)
      if (BSZ[b] != 0)
        for (int k = 0; k < 4; k++) mdl[u][16 + 4*b + k] = BTY[b][8*k +: 8];
  endtask

  // Applies one write to the model; returns expected strobe and a requirement tag.
  task automatic model_write(int u, logic [7:0] off, logic [1:0] code, logic [31:0] d,
                             output bit stb, output string tag);
    logic [7:0] h, a;
    logic [31:0] v;
    bit special;
    int n, b;
    h = mdl[u][14]; n = nbytes_of(code); special = 0; v = '0; stb = 0; tag = "R6";
    if (n == 4 && off[1:0] == 2'b00) begin
      if (off >= 8'h10 && off <= 8'h24) begin
        b = (int'(off) - 16) / 4;
        if (BSZ[b] != 0) begin special = 1; v = (d & ~(BSZ[b] - 1)) | BTY[b]; tag = "R7"; end
      end else if (off == 8'h30 && ROMSZ != 0) begin
        special = 1; v = d & (~(ROMSZ - 1) | 32'd1); tag = "R8";
      end
    end
    stb = special;
    for (int k = 0; k < n; k++) begin
      a = off + 8'(k);
      if (special) mdl[u][a] = v[8*k +: 8];
      else if (!locked(h, a)) mdl[u][a] = d[8*k +: 8];
      else tag = (h == 8'h00 || h == 8'h80) ? "R4" : "R5";
      if (a == 8'h04 || a == 8'h05) stb = 1;
    end
    if (!special && ((off >= 8'h10 && off <= 8'h27) || (off >= 8'h30 && off <= 8'h33)))
      tag = (tag == "R6") ? "R9" : tag;
  endtask

  function automatic logic [31:0] model_read(int u, logic [7:0] off, logic [1:0] code);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < nbytes_of(code); k++) r[8*k +: 8] = mdl[u][off + 8'(k)];
    return r;
  endfunction

  task automatic check_exports(string tag);
    chk({tag, " R11 cmd a"}, {16'h0, cmd_a}, {16'h0, mdl[0][5], mdl[0][4]});
    chk({tag, " R11 cmd b"}, {16'h0, cmd_b}, {16'h0, mdl[1][5], mdl[1][4]});
    chk({tag, " R11 rom a"}, rom_a, {mdl[0][51], mdl[0][50], mdl[0][49], mdl[0][48]});
    chk({tag, " R11 rom b"}, rom_b, {mdl[1][51], mdl[1][50], mdl[1][49], mdl[1][48]});
    for (int b = 0; b < NB; b++) begin
      chk({tag, " R11 bar a"}, bar_a[32*b +: 32],
          {mdl[0][19+4*b], mdl[0][18+4*b], mdl[0][17+4*b], mdl[0][16+4*b]});
      chk({tag, " R11 bar b"}, bar_b[32*b +: 32],
          {mdl[1][19+4*b], mdl[1][18+4*b], mdl[1][17+4*b], mdl[1][16+4*b]});
    end
  endtask

  task automatic do_read(logic [7:0] off, logic [1:0] code, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_offset = off; req_size = code;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R2 valid a"}, {31'h0, rsp_valid_a}, 32'h1);
    chk({tag, " rdata a"}, rsp_rdata_a, model_read(0, off, code));
    chk({tag, " rdata b"}, rsp_rdata_b, model_read(1, off, code));
  endtask

  task automatic do_write(logic [7:0] off, logic [1:0] code, logic [31:0] d,
                          bit full_exports, output string tag_a, output string tag_b);
    bit sa, sb;
    model_write(0, off, code, d, sa, tag_a);
    model_write(1, off, code, d, sb, tag_b);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_offset = off; req_size = code; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R10 strobe a", {31'h0, map_update_a}, {31'h0, sa});
    chk("R10 strobe b", {31'h0, map_update_b}, {31'h0, sb});
    chk("R12 no rsp", {30'h0, rsp_valid_a, rsp_valid_b}, 32'h0);
    if (full_exports) check_exports(tag_a);
  endtask

  task automatic write_check(logic [7:0] off, logic [1:0] code, logic [31:0] d);
    string ta, tb;
    do_write(off, code, d, 0, ta, tb);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_offset = off; req_size = code;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({ta, " readback a"}, rsp_rdata_a, model_read(0, off, code));
    chk({tb, " readback b"}, rsp_rdata_b, model_read(1, off, code));
  endtask

  task automatic dump_all(string tag);
    for (int w = 0; w < 64; w++) do_read(8'(4 * w), 2'd2, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string ta, tb;
    model_init(0, HDR_A);
    model_init(1, HDR_B);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset rsp", {30'h0, rsp_valid_a, map_update_a}, 32'h0);
    rst_n = 1;
    check_exports("R3");
    dump_all("R3");

    // R1: wrap-around and size code 3
    do_read(8'hFE, 2'd2, "R1 wrap");
    do_read(8'h01, 2'd3, "R1 code3");
    do_read(8'h09, 2'd1, "R1 half");

    // Single-byte sweep (R4, R5, R6)
    for (int a = 0; a < 256; a++)
      write_check(8'(a), 2'd0, 32'(((a * 37) ^ 8'hA5) & 8'hFF) | 32'hEEEEEE00);
    // Two-byte sweep (R6, R9)
    for (int a = 0; a < 256; a++)
      write_check(8'(a), 2'd1, (32'(a) * 32'h0001_0203) ^ 32'hFFFF_5A3C);
    // Four-byte sweep, aligned and unaligned (R7, R8, R9)
    for (int a = 0; a < 256; a++)
      write_check(8'(a), 2'd2, (32'(a) * 32'h0103_0507) ^ 32'hC33C_A55A);

    // Explicit BAR/ROM sizing probes with full export checks (R7, R8, R9, R11)
    for (int b = 0; b < NB; b++) begin
      do_write(8'(16 + 4*b), 2'd2, 32'hFFFF_FFFF, 1, ta, tb);
      do_write(8'(16 + 4*b), 2'd2, 32'h1234_5677, 1, ta, tb);
    end
    do_write(8'h30, 2'd2, 32'hFFFF_FFFF, 1, ta, tb);
    do_write(8'h30, 2'd2, 32'hABCD_E001, 1, ta, tb);
    do_write(8'h10, 2'd1, 32'h0000_BEEF, 1, ta, tb);   // R9 half-word to BAR
    do_write(8'h11, 2'd2, 32'h1111_1111, 1, ta, tb);   // R9 unaligned word
    do_write(8'h04, 2'd1, 32'h0000_0107, 1, ta, tb);   // R10 command write
    do_write(8'h05, 2'd0, 32'h0000_0003, 1, ta, tb);   // R10 upper command byte
    do_write(8'h06, 2'd1, 32'h0000_FFFF, 1, ta, tb);   // R10 no strobe

    // Back-pressure with a write waiting behind a held response (R2, R10, R12)
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_offset = 8'h00; req_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    req_write = 1; req_offset = 8'h04; req_size = 2'd1; req_wdata = 32'h0000_0146;
    for (int c = 0; c < 3; c++) begin
      chk("R2 held valid", {31'h0, rsp_valid_a}, 32'h1);
      chk("R2 held data", rsp_rdata_a, model_read(0, 8'h00, 2'd2));
      chk("R2 ready low", {30'h0, req_ready_a, req_ready_b}, 32'h0);
      @(posedge clk);
      @(negedge clk);
    end
    rsp_ready = 1;
    model_write(0, 8'h04, 2'd1, 32'h0000_0146, ta_dummy_a, ta);
    model_write(1, 8'h04, 2'd1, 32'h0000_0146, ta_dummy_b, tb);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R12 drained with write", {30'h0, rsp_valid_a, rsp_valid_b}, 32'h0);
    chk("R10 strobe on drain edge", {30'h0, map_update_a, map_update_b}, 32'h3);
    check_exports("R2");
    @(negedge clk);
    chk("R10 strobe one cycle", {30'h0, map_update_a, map_update_b}, 32'h0);

    dump_all("R6 final");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  bit ta_dummy_a, ta_dummy_b;

endmodule